// File: doc/BRIEF.md
# Parallel display write sequencer

This block drives the write side of an 8080-style parallel bus into a TFT display controller. The bus has a 16-bit data path, an active-low write strobe and a data/command select line. The block takes 32-bit words from a valid/ready stream. In pixel mode each accepted word becomes one bus write of its low half.

When the mode input is high while the block is idle, it starts a fixed address-window sequence instead. Three command words are taken from the same stream and sent with the select line low. After each of the first two commands, one 32-bit argument word is taken and sent as four byte-wide writes with the select line high, starting with the lowest byte. The commands and the arguments use different strobe widths.

After the third command no arguments follow. The select line returns high and the block goes back to pixel mode. A busy output covers the whole sequence.

Top module: `tft_wr_seq`

## Requirements
- R1: After reset the strobe `wr_n` is 1, `dc` is 1, `busy` is 0, `bus_data` is 0, and the block is idle in pixel mode with `in_ready` high.
- R2: In pixel mode each accepted word produces exactly one bus write. During that write `bus_data` equals bits 15:0 of the word and `dc` is 1.
- R3: A pixel write holds `wr_n` low for exactly two clocks. `wr_n` is then high for at least one clock before the next write, and `in_ready` is low while `wr_n` is low.
- R4: While `in_valid` is low at any fetch point, no write starts. `wr_n` stays high and `bus_data` and `dc` keep their values.
- R5: `win_req` is looked at only when the block is idle at the pixel fetch point. There it holds `in_ready` low and starts the window sequence. A `win_req` pulse that ends before the block returns to idle has no effect.
- R6: A window sequence sends the next three stream words as commands in arrival order. Each command is bits 15:0 of its word, with `wr_n` low for exactly one clock, and `dc` is 0 from at least one clock before the strobe falls.
- R7: After the first and second commands only, one argument word is accepted and sent as four writes. The bytes go out in the order bits 7:0, 15:8, 23:16, 31:24, each on `bus_data[7:0]` with `bus_data[15:8]` zero. `dc` is 1 from at least one clock before the first byte's strobe.
- R8: Each argument byte holds `wr_n` low for two clocks. Consecutive bytes of one word are separated by exactly two clocks of `wr_n` high.
- R9: After the third command `wr_n` is high for exactly one clock with `dc` still 0. Then `dc` goes to 1 and the block is back in pixel mode. A window sequence consumes exactly five stream words.
- R10: `busy` rises on the clock after `win_req` is taken at idle. It stays high until the same edge on which `dc` returns to 1. `busy` is never 0 while `dc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_req | input | 1 | Request for an address-window sequence, taken only at idle |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Stream word accepted on a clock edge where valid and ready are both high |
| bus_data | output | 16 | Parallel bus data |
| wr_n | output | 1 | Active-low write strobe; the display latches data on its rising edge |
| dc | output | 1 | Data/command select, 0 for a command |
| busy | output | 1 | High during a window sequence |

## Verification
A stream handshake changes the bus on the very next edge. All outputs are registered, so a strobe falls one clock after its word is taken, and `dc` moves one clock ahead of the strobe it qualifies. The strobe widths of two, one and two clocks, and the two-clock gap between bytes, are counted in whole clocks. The bench does not try to predict absolute cycle numbers. A monitor samples the bus on every falling clock edge and records each write, with its data, its select level, the select level one clock earlier, its low width and the high run before it. Each check compares these records, or the timing of `dc` returning high after the last strobe, with the values the requirements fix.

// File: rtl/tft_seq_pkg.sv
// Shared types for the parallel display write sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tft_seq_pkg;

    // Controller states; one state per bus phase
    typedef enum logic [3:0] {
        ST_FETCH   = 4'd0,   // idle, pixel fetch point
        ST_PX_LO   = 4'd1,   // pixel strobe low
        ST_PX_HI   = 4'd2,   // pixel strobe recovery
        ST_W_INIT  = 4'd3,   // window sequence start, select goes to command
        ST_C_FETCH = 4'd4,   // waiting for a command word
        ST_C_LO    = 4'd5,   // command strobe low (one clock)
        ST_P_FETCH = 4'd6,   // waiting for an argument word
        ST_P_DC    = 4'd7,   // select high, first byte pending
        ST_B_LO    = 4'd8,   // argument byte strobe low
        ST_B_HI    = 4'd9,   // argument byte strobe high
        ST_NEXT    = 4'd10,  // step to next command
        ST_LAST    = 4'd11   // extra high clock after final command
    } seq_state_t;

    // One-cycle actions the controller requests from the datapath
    typedef struct packed {
        logic px_load;    // drive pixel half-word, strobe low
        logic cmd_load;   // drive command half-word, strobe low
        logic word_load;  // capture argument word into the byte shifter
        logic byte_out;   // drive next argument byte, strobe low
        logic wr_rise;    // release strobe
        logic dc_fall;    // select command
        logic dc_rise;    // select data
    } bus_ctl_t;

endpackage

// File: rtl/tft_seq_ctrl.sv
// Sequencing controller for the parallel display write sequencer.
// Decides per clock which bus phase runs and which datapath action fires.
// Assumes: all timing counts are at least 1; CMD_CNT is at least 1.
module tft_seq_ctrl
    import tft_seq_pkg::*;
#(
    parameter int PX_LO_CYC   = 2,
    parameter int BYTE_LO_CYC = 2,
    parameter int BYTE_HI_CYC = 2,
    parameter int CMD_CNT     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_req,
    input  logic       in_valid,
    input  logic       shift_empty,
    output logic       in_ready,
    output logic       busy,
    output bus_ctl_t   ctl
);

    localparam int PH_MAX_A = (PX_LO_CYC > BYTE_LO_CYC) ? PX_LO_CYC : BYTE_LO_CYC;
    localparam int PH_MAX   = (PH_MAX_A > BYTE_HI_CYC) ? PH_MAX_A : BYTE_HI_CYC;
    localparam int PH_W     = $clog2(PH_MAX + 1);
    localparam int CMD_W    = $clog2(CMD_CNT + 1);
    localparam logic [PH_W-1:0]  PX_LAST  = PH_W'(PX_LO_CYC - 1);
    localparam logic [PH_W-1:0]  BLO_LAST = PH_W'(BYTE_LO_CYC - 1);
    localparam logic [PH_W-1:0]  BHI_LAST = PH_W'(BYTE_HI_CYC - 1);
    localparam logic [CMD_W-1:0] CMD_INIT = CMD_W'(CMD_CNT - 1);

    seq_state_t       st, st_nxt;
    logic [PH_W-1:0]  ph, ph_nxt;
    logic [CMD_W-1:0] left, left_nxt;

    // Stream ready only in the three fetch phases (pixel fetch yields to a window request)
    always_comb begin
        in_ready = ((st == ST_FETCH) && !win_req) ||
                   (st == ST_C_FETCH) || (st == ST_P_FETCH);
    end

    // Busy covers every state that belongs to the window sequence
    always_comb begin
        busy = !((st == ST_FETCH) || (st == ST_PX_LO) || (st == ST_PX_HI));
    end

    // Next-state, phase counter and datapath actions
    always_comb begin
        st_nxt   = st;
        ph_nxt   = ph;
        left_nxt = left;
        ctl      = '0;
        unique case (st)
            ST_FETCH: begin
                if (win_req) begin
                    st_nxt = ST_W_INIT;
                end else if (in_valid) begin
                    ctl.px_load = 1'b1;
                    ph_nxt      = '0;
                    st_nxt      = ST_PX_LO;
                end
            end
            ST_PX_LO: begin
                if (ph == PX_LAST) begin
                    ctl.wr_rise = 1'b1;
                    st_nxt      = ST_PX_HI;
                end else begin
                    ph_nxt = ph + 1'b1;
                end
            end
            ST_PX_HI: begin
                st_nxt = ST_FETCH;
            end
            ST_W_INIT: begin
                left_nxt    = CMD_INIT;
                ctl.dc_fall = 1'b1;
                st_nxt      = ST_C_FETCH;
            end
            ST_C_FETCH: begin
                if (in_valid) begin
                    ctl.cmd_load = 1'b1;
                    st_nxt       = ST_C_LO;
                end
            end
            ST_C_LO: begin
                ctl.wr_rise = 1'b1;
                st_nxt      = (left == '0) ? ST_LAST : ST_P_FETCH;
            end
            ST_P_FETCH: begin
                if (in_valid) begin
                    ctl.word_load = 1'b1;
                    ctl.dc_rise   = 1'b1;
                    st_nxt        = ST_P_DC;
                end
            end
            ST_P_DC: begin
                ctl.byte_out = 1'b1;
                ph_nxt       = '0;
                st_nxt       = ST_B_LO;
            end
            ST_B_LO: begin
                if (ph == BLO_LAST) begin
                    ctl.wr_rise = 1'b1;
                    ph_nxt      = '0;
                    st_nxt      = ST_B_HI;
                end else begin
                    ph_nxt = ph + 1'b1;
                end
            end
            ST_B_HI: begin
                if (ph == BHI_LAST) begin
                    if (shift_empty) begin
                        st_nxt = ST_NEXT;
                    end else begin
                        ctl.byte_out = 1'b1;
                        ph_nxt       = '0;
                        st_nxt       = ST_B_LO;
                    end
                end else begin
                    ph_nxt = ph + 1'b1;
                end
            end
            ST_NEXT: begin
                left_nxt    = left - 1'b1;
                ctl.dc_fall = 1'b1;
                st_nxt      = ST_C_FETCH;
            end
            ST_LAST: begin
                ctl.dc_rise = 1'b1;
                st_nxt      = ST_FETCH;
            end
            default: begin
                st_nxt = ST_FETCH;
            end
        endcase
    end

    // State, phase and command-counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_FETCH;
            ph   <= '0;
            left <= '0;
        end else begin
            st   <= st_nxt;
            ph   <= ph_nxt;
            left <= left_nxt;
        end
    end

endmodule

// File: rtl/tft_seq_shifter.sv
// Argument word shifter: holds one word and hands out its bytes, low byte first.
// Assumes: WORD_W is a whole multiple of BYTE_W.
module tft_seq_shifter #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_load,
    input  logic              byte_out,
    input  logic [WORD_W-1:0] word_in,
    output logic [BYTE_W-1:0] cur_byte,
    output logic              empty
);

    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  rem;

    // Lowest byte not yet sent is always at the bottom
    always_comb begin
        cur_byte = sh[BYTE_W-1:0];
        empty    = (rem == '0);
    end

    // Load a word or move the next byte to the bottom
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            rem <= '0;
        end else if (word_load) begin
            sh  <= word_in;
            rem <= CNT_W'(NBYTES);
        end else if (byte_out) begin
            sh  <= sh >> BYTE_W;
            rem <= rem - 1'b1;
        end
    end

endmodule

// File: rtl/tft_seq_bus.sv
// Bus output registers: data, write strobe and data/command select.
// Assumes: at most one of the load actions fires per clock; BYTE_W <= DATA_W.
module tft_seq_bus
    import tft_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ctl_t          ctl,
    input  logic [DATA_W-1:0] half_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [DATA_W-1:0] bus_data,
    output logic              wr_n,
    output logic              dc
);

    logic [DATA_W-1:0] byte_ext;

    // Zero-extend the argument byte onto the full bus width
    generate
        if (DATA_W > BYTE_W) begin : g_pad
            always_comb byte_ext = {{(DATA_W-BYTE_W){1'b0}}, byte_in};
        end else begin : g_same
            always_comb byte_ext = byte_in;
        end
    endgenerate

    // Data and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_data <= '0;
            wr_n     <= 1'b1;
        end else if (ctl.px_load || ctl.cmd_load) begin
            bus_data <= half_in;
            wr_n     <= 1'b0;
        end else if (ctl.byte_out) begin
            bus_data <= byte_ext;
            wr_n     <= 1'b0;
        end else if (ctl.wr_rise) begin
            wr_n     <= 1'b1;
        end
    end

    // Select register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc <= 1'b1;
        end else if (ctl.dc_fall) begin
            dc <= 1'b0;
        end else if (ctl.dc_rise) begin
            dc <= 1'b1;
        end
    end

endmodule

// File: rtl/tft_wr_seq.sv
// Top of the parallel display write sequencer.
// Pixel words go out one per write; a window request runs three commands
// with byte-wise arguments after the first two.
// Assumes: stream words are held stable while in_valid is high and not yet taken.
module tft_wr_seq
    import tft_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int WORD_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int PX_LO_CYC   = 2,
    parameter int BYTE_LO_CYC = 2,
    parameter int BYTE_HI_CYC = 2,
    parameter int CMD_CNT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_req,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic [DATA_W-1:0] bus_data,
    output logic              wr_n,
    output logic              dc,
    output logic              busy
);

    bus_ctl_t          ctl;
    logic              shift_empty;
    logic [BYTE_W-1:0] cur_byte;

    tft_seq_ctrl #(
        .PX_LO_CYC  (PX_LO_CYC),
        .BYTE_LO_CYC(BYTE_LO_CYC),
        .BYTE_HI_CYC(BYTE_HI_CYC),
        .CMD_CNT    (CMD_CNT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_req    (win_req),
        .in_valid   (in_valid),
        .shift_empty(shift_empty),
        .in_ready   (in_ready),
        .busy       (busy),
        .ctl        (ctl)
    );

    tft_seq_shifter #(
        .WORD_W(WORD_W),
        .BYTE_W(BYTE_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_load(ctl.word_load),
        .byte_out (ctl.byte_out),
        .word_in  (in_data),
        .cur_byte (cur_byte),
        .empty    (shift_empty)
    );

    tft_seq_bus #(
        .DATA_W(DATA_W),
        .BYTE_W(BYTE_W)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .half_in (in_data[DATA_W-1:0]),
        .byte_in (cur_byte),
        .bus_data(bus_data),
        .wr_n    (wr_n),
        .dc      (dc)
    );

endmodule

// File: rtl/tft_seq_chk.sv
// Port-level protocol checker for the write sequencer, bound to the top.
// Assumes: default parameters (two-clock pixel strobe, one-clock command strobe).
module tft_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] bus_data,
    input logic              wr_n,
    input logic              dc,
    input logic              busy
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wr_n && dc && !busy && in_ready));

    // R3
    px_strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && dc && !busy) |=> !wr_n);

    // R3
    no_take_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !in_ready);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (wr_n && $stable(bus_data) && $stable(dc)));

    // R6
    cmd_strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && !dc) |=> wr_n);

    // R6
    dc_steady_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> $stable(dc));

    // R10
    busy_covers_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> dc);

endmodule

bind tft_wr_seq tft_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .bus_data(bus_data),
    .wr_n    (wr_n),
    .dc      (dc),
    .busy    (busy)
);

// File: tb/tft_wr_seq_test.sv
`timescale 1ns/1ps
// Bench for the parallel display write sequencer.
module tft_wr_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_req = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic [15:0] bus_data;
    logic        wr_n;
    logic        dc;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tft_wr_seq uut (
        .clk(clk), .rst_n(rst_n), .win_req(win_req),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .bus_data(bus_data), .wr_n(wr_n), .dc(dc), .busy(busy)
    );

    // Pixel vectors: stream word and the half-word expected on the bus (R2)
    localparam int NPX = 6;
    localparam logic [31:0] PX_WORD [NPX] = '{32'hDEAD_1234, 32'h0000_FFFF, 32'hFFFF_0000,
                                             32'h8001_A5A5, 32'h1234_0001, 32'h7F7F_8000};
    localparam logic [15:0] PX_EXP  [NPX] = '{16'h1234, 16'hFFFF, 16'h0000,
                                             16'hA5A5, 16'h0001, 16'h8000};

    // Window sequence: expected writes (data, select, low width)
    localparam int NWIN = 11;
    localparam logic [15:0] W_DATA [NWIN] = '{16'h002A, 16'h0044, 16'h0033, 16'h0022, 16'h0011,
                                             16'h002B, 16'h00DD, 16'h00CC, 16'h00BB, 16'h00AA,
                                             16'h002C};
    localparam logic        W_DC   [NWIN] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                             1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam int          W_LO   [NWIN] = '{1, 2, 2, 2, 2, 1, 2, 2, 2, 2, 1};

    // Write monitor, sampled on falling clock edges
    logic [15:0] ev_data [64];
    logic        ev_dc   [64];
    logic        ev_pre  [64];
    int          ev_lo   [64];
    int          ev_gap  [64];
    int   ev_n = 0;
    int   lo_run = 0;
    int   hi_run = 0;
    logic prev_wr = 1'b1;
    logic prev_dc = 1'b1;
    logic prev_busy = 1'b0;
    int   dc_rise_gap = -1;
    logic busy_at_rise = 1'b1;
    logic busy_before_rise = 1'b0;
    int   busy_dc_viol = 0;
    int   takes = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            lo_run = 0; hi_run = 0; prev_wr = 1'b1; prev_dc = 1'b1; prev_busy = 1'b0;
        end else begin
            if (!busy && !dc) busy_dc_viol++;
            if (dc && !prev_dc) begin
                dc_rise_gap = hi_run;
                busy_at_rise = busy;
                busy_before_rise = prev_busy;
            end
            if (!wr_n) begin
                if (prev_wr) begin
                    ev_data[ev_n] = bus_data;
                    ev_dc[ev_n]   = dc;
                    ev_pre[ev_n]  = prev_dc;
                    ev_gap[ev_n]  = hi_run;
                end
                lo_run++;
                hi_run = 0;
            end else begin
                if (!prev_wr) begin
                    ev_lo[ev_n] = lo_run;
                    if (ev_n < 63) ev_n++;
                    lo_run = 0;
                end
                hi_run++;
            end
            prev_wr = wr_n; prev_dc = dc; prev_busy = busy;
        end
    end

    // Count accepted stream words
    always @(posedge clk) begin
        if (rst_n && in_valid && in_ready) takes++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Offer one word, called at a falling edge; returns at the falling edge after it is taken
    task automatic push(input logic [31:0] w);
        in_data = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        int base;
        int t0;
        logic [15:0] held;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "wr_n", wr_n, 1);
        chk("R1", "dc", dc, 1);
        chk("R1", "busy", busy, 0);
        chk("R1", "bus_data", bus_data, 0);
        chk("R1", "in_ready", in_ready, 1);

        // R2 / R3 pixel table walk
        base = ev_n;
        for (int i = 0; i < NPX; i++) push(PX_WORD[i]);
        idle(6);
        chk("R2", "pixel write count", ev_n - base, NPX);
        for (int i = 0; i < NPX; i++) begin
            chk("R2", "pixel data", ev_data[base+i], PX_EXP[i]);
            chk("R2", "pixel dc", ev_dc[base+i], 1);
            chk("R3", "pixel low width", ev_lo[base+i], 2);
            if (i > 0) chk("R3", "pixel high gap >=1", ev_gap[base+i] >= 1, 1);
        end

        // R4 stall with no valid data
        base = ev_n;
        held = bus_data;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (wr_n !== 1'b1 || bus_data !== held || dc !== 1'b1)
                chk("R4", "stall hold", {wr_n, dc, bus_data}, {2'b11, held});
        end
        chk("R4", "no write while stalled", ev_n - base, 0);
        chk("R4", "bus data held", bus_data, held);

        // R5 request pulse away from the idle fetch point is ignored
        base = ev_n;
        in_data = 32'h0BAD_4321; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        win_req = 1'b1;
        @(negedge clk);
        chk("R5", "busy during ignored request", busy, 0);
        @(negedge clk);
        win_req = 1'b0;
        idle(3);
        chk("R5", "no window started", busy, 0);
        chk("R5", "dc after ignored request", dc, 1);
        push(32'h0000_5678);
        idle(4);
        chk("R5", "pixel writes after ignored request", ev_n - base, 2);
        chk("R5", "following pixel data", ev_data[base+1], 16'h5678);
        chk("R5", "following pixel dc", ev_dc[base+1], 1);

        // R6..R10 window sequence
        base = ev_n;
        t0 = takes;
        win_req = 1'b1;
        #1;
        chk("R5", "ready low on request at idle", in_ready, 0);
        @(negedge clk);
        win_req = 1'b0;
        chk("R10", "busy one clock after request", busy, 1);
        push(32'h5A5A_002A);
        push(32'h1122_3344);
        push(32'hC3C3_002B);
        idle(5);                 // stall inside the sequence
        push(32'hAABB_CCDD);
        push(32'h0F0F_002C);
        idle(12);
        chk("R9", "words consumed by window", takes - t0, 5);
        chk("R6", "window write count", ev_n - base, NWIN);
        for (int i = 0; i < NWIN; i++) begin
            chk(W_DC[i] ? "R7" : "R6", "window data", ev_data[base+i], W_DATA[i]);
            chk(W_DC[i] ? "R7" : "R6", "window dc", ev_dc[base+i], W_DC[i]);
            chk(W_DC[i] ? "R8" : "R6", "window low width", ev_lo[base+i], W_LO[i]);
        end
        chk("R6", "dc low before first cmd", ev_pre[base+0], 0);
        chk("R6", "dc low before second cmd", ev_pre[base+5], 0);
        chk("R6", "dc low before third cmd", ev_pre[base+10], 0);
        chk("R7", "dc high before first byte", ev_pre[base+1], 1);
        chk("R7", "dc high before fifth byte", ev_pre[base+6], 1);
        for (int i = 2; i <= 4; i++) chk("R8", "byte gap", ev_gap[base+i], 2);
        for (int i = 7; i <= 9; i++) chk("R8", "byte gap", ev_gap[base+i], 2);
        chk("R9", "extra high clock before dc rise", dc_rise_gap, 1);
        chk("R9", "dc back high", dc, 1);
        chk("R10", "busy low with dc rise", busy_at_rise, 0);
        chk("R10", "busy high before dc rise", busy_before_rise, 1);
        chk("R10", "busy never low with dc low", busy_dc_viol, 0);

        // R9 back in pixel mode
        base = ev_n;
        push(32'h4444_9ABC);
        idle(4);
        chk("R9", "pixel after window", ev_data[base], 16'h9ABC);
        chk("R9", "pixel dc after window", ev_dc[base], 1);

        // R1 reset in the middle of a window sequence
        win_req = 1'b1;
        @(negedge clk);
        win_req = 1'b0;
        push(32'h0000_002A);
        rst_n = 1'b0;
        idle(2);
        chk("R1", "mid reset wr_n", wr_n, 1);
        chk("R1", "mid reset dc", dc, 1);
        chk("R1", "mid reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", in_ready, 1);

        finish_run();
    end

endmodule